// File: doc/BRIEF.md
# Prescaled Interval and Pulse-Width Timer

An 8-bit down-counter with a clock prescaler, a 5-bit control word and a reload value. A 4-bit mode field picks what feeds the counter: nothing (stopped), prescaled ticks (delay), edges on an external event pin (event count), or prescaled ticks gated by an external level (pulse width). Each time the counter runs out it reloads, toggles a square-wave output and, outside pulse-width mode, raises a one-cycle interrupt. In pulse-width mode the interrupt instead marks the end of the gate window.

Software first writes the reload value while the timer is stopped, which also loads the counter. It then selects a mode. Writing a new reload value while the timer runs only takes effect at the next reload. A separate control bit forces the square-wave output low.

Top module: `prescaled_timer`

## Requirements
- R1: After reset count_o is 0, timer_o is 0 and irq_o is 0, and the mode is stopped.
- R2: With mode field ctrl_wdata_i[3:0] = 0 the counter holds its value. A data write loads count_o in the next cycle.
- R3: Modes 1 to 7 are delay modes. The low three mode bits 1..7 select prescale ratios 4, 10, 16, 50, 64, 100 and 200. The counter decrements once per ratio cycles, so the first timeout falls exactly ratio times data cycles after the mode write.
- R4: A decrement that finds the counter at 1 reloads it from the data value and toggles timer_o. Outside pulse-width mode it also drives irq_o high for exactly one cycle.
- R5: A data value of 0 counts as 256 decrements per period.
- R6: A data write while the timer runs leaves count_o unchanged and is used at the next reload.
- R7: A control write with ctrl_wdata_i[4] = 1 forces timer_o to 0 in the next cycle.
- R8: Mode 8 is event count. The counter decrements once per rising edge of event_i, after a two-flop synchroniser, and does not move without edges.
- R9: Modes 9 to 15 are pulse width and use the same ratios from the low three bits. Ticks decrement the counter only while the synchronised gate_i is high. irq_o pulses once on the gate's falling edge and not on timeouts.
- R10: A control write that changes the mode field clears the prescale count, so the first tick after the change takes a full new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 5 | Bit 4 output clear, bits 3:0 mode |
| data_we_i | input | 1 | Data (reload) write strobe |
| data_wdata_i | input | 8 | Reload value |
| event_i | input | 1 | Asynchronous event input |
| gate_i | input | 1 | Asynchronous gate input for pulse-width mode |
| count_o | output | 8 | Current counter value |
| timer_o | output | 1 | Square-wave output, toggles per timeout |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
Each of the seven delay ratios is run with data values from the directed list and from the random list. The timeout is then sampled one cycle early and on the exact cycle, which tells a correct ratio apart from a neighbouring one or from an off-by-one in the reload. Separate runs cover the following cases:
- A data value of 0 and a mid-run data write show 256-count wrap and deferred reload.
- A switch from the slowest to the fastest ratio mid-period shows whether the prescale count is cleared.
- Event pulses and gate windows, with and without activity, show which source feeds the counter.
- In pulse-width mode, irq_o is counted separately from the timeout toggles to show where it comes from.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  localparam int MODE_W = 4;
  localparam int SEL_W  = 3;

  typedef enum logic [1:0] {
    CLS_STOP  = 2'd0,
    CLS_DELAY = 2'd1,
    CLS_EVENT = 2'd2,
    CLS_PULSE = 2'd3
  } mode_cls_e;

  function automatic int unsigned prescale_div(logic [SEL_W-1:0] sel);
    case (sel)
      3'd1:    return 4;
      3'd2:    return 10;
      3'd3:    return 16;
      3'd4:    return 50;
      3'd5:    return 64;
      3'd6:    return 100;
      3'd7:    return 200;
      default: return 1;
    endcase
  endfunction

  function automatic mode_cls_e classify(logic [MODE_W-1:0] m);
    if (m == '0)               return CLS_STOP;
    else if (m == 4'd8)        return CLS_EVENT;
    else if (m[MODE_W-1])      return CLS_PULSE;
    else                       return CLS_DELAY;
  endfunction
endpackage

// File: rtl/ptimer_edge_sync.sv
module ptimer_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic level_o,
  output logic prev_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], d_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign level_o = sh_q[STAGES-1];
  assign prev_o  = prev_q;
endmodule

// File: rtl/ptimer_prescaler.sv
module ptimer_prescaler
  import ptimer_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pcnt_q;
  logic [PRE_W-1:0] div_m1;

  assign div_m1 = PRE_W'(prescale_div(sel_i) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       pcnt_q <= '0;
    else if (clear_i || !run_i)        pcnt_q <= '0;
    else if (pcnt_q == div_m1)         pcnt_q <= '0;
    else                               pcnt_q <= pcnt_q + 1'b1;
  end

  assign tick_o = run_i && !clear_i && (pcnt_q == div_m1);

  p_pcnt_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcnt_q <= div_m1);
  p_clear_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> pcnt_q == '0);
endmodule

// File: rtl/ptimer_counter.sv
module ptimer_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stopped_i,
  input  logic             pulse_i,
  input  logic             dec_i,
  input  logic             gate_fall_i,
  input  logic             clr_out_i,
  input  logic             data_we_i,
  input  logic [CNT_W-1:0] data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             timer_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, reload_q;
  logic             timer_q, irq_q, expire;

  assign expire = dec_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= '0;
      timer_q  <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (data_we_i) reload_q <= data_i;
      if (data_we_i && stopped_i) cnt_q <= data_i;
      else if (expire)            cnt_q <= reload_q;
      else if (dec_i)             cnt_q <= cnt_q - 1'b1; // 0 wraps: 256 counts
      if (clr_out_i)   timer_q <= 1'b0;
      else if (expire) timer_q <= ~timer_q;
      irq_q <= pulse_i ? gate_fall_i : expire;
    end
  end

  assign cnt_o   = cnt_q;
  assign timer_o = timer_q;
  assign irq_o   = irq_q;

  p_stop_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped_i && !data_we_i |=> $stable(cnt_q));
  p_irq_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !pulse_i |=> !irq_q);
  p_reload_on_toggle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timer_q) && !$past(data_we_i) |-> cnt_q == reload_q);
  p_run_write_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stopped_i && data_we_i && !dec_i |=> $stable(cnt_q));
  p_clear_out_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_out_i |=> !timer_q);
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import ptimer_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic [4:0]       ctrl_wdata_i,
  input  logic             data_we_i,
  input  logic [CNT_W-1:0] data_wdata_i,
  input  logic             event_i,
  input  logic             gate_i,
  output logic [CNT_W-1:0] count_o,
  output logic             timer_o,
  output logic             irq_o
);
  localparam int CLR_BIT = MODE_W;

  logic [MODE_W-1:0] mode_q;
  mode_cls_e         cls;
  logic              mode_chg, run_pre, tick;
  logic              ev_lvl, ev_prev, gt_lvl, gt_prev;
  logic              ev_rise, gt_fall, dec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= '0;
    else if (ctrl_we_i) mode_q <= ctrl_wdata_i[MODE_W-1:0];
  end

  assign cls      = classify(mode_q);
  assign mode_chg = ctrl_we_i && (ctrl_wdata_i[MODE_W-1:0] != mode_q);
  assign run_pre  = (cls == CLS_DELAY) || (cls == CLS_PULSE);

  ptimer_prescaler #(.PRE_W(PRE_W)) i_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_pre),
    .clear_i (mode_chg),
    .sel_i   (mode_q[SEL_W-1:0]),
    .tick_o  (tick)
  );

  ptimer_edge_sync #(.STAGES(SYNC_STAGES)) i_ev_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     (event_i),
    .level_o (ev_lvl),
    .prev_o  (ev_prev)
  );

  ptimer_edge_sync #(.STAGES(SYNC_STAGES)) i_gate_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     (gate_i),
    .level_o (gt_lvl),
    .prev_o  (gt_prev)
  );

  assign ev_rise = ev_lvl && !ev_prev;
  assign gt_fall = !gt_lvl && gt_prev;

  always_comb begin
    unique case (cls)
      CLS_DELAY: dec = tick;
      CLS_EVENT: dec = ev_rise;
      CLS_PULSE: dec = tick && gt_lvl;
      default:   dec = 1'b0;
    endcase
  end

  ptimer_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stopped_i   (cls == CLS_STOP),
    .pulse_i     (cls == CLS_PULSE),
    .dec_i       (dec),
    .gate_fall_i (gt_fall),
    .clr_out_i   (ctrl_we_i && ctrl_wdata_i[CLR_BIT]),
    .data_we_i   (data_we_i),
    .data_i      (data_wdata_i),
    .cnt_o       (count_o),
    .timer_o     (timer_o),
    .irq_o       (irq_o)
  );

  p_event_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cls == CLS_EVENT && !ev_rise && !data_we_i |=> $stable(count_o));
  p_gate_low_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cls == CLS_PULSE && !gt_lvl && !data_we_i |=> $stable(count_o));
endmodule

// File: tb/test_prescaled_timer.sv
module test_prescaled_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctrl_we_i = 1'b0;
  logic [4:0] ctrl_wdata_i = '0;
  logic       data_we_i = 1'b0;
  logic [7:0] data_wdata_i = '0;
  logic       event_i = 1'b0;
  logic       gate_i = 1'b0;
  logic [7:0] count_o;
  logic       timer_o, irq_o;

  int checks = 0;
  int fails = 0;
  int irq_seen = 0;
  int tog_seen = 0;
  logic last_timer = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prescaled_timer i_prescaled_timer (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i),
    .data_we_i(data_we_i), .data_wdata_i(data_wdata_i), .event_i(event_i),
    .gate_i(gate_i), .count_o(count_o), .timer_o(timer_o), .irq_o(irq_o)
  );

  always @(negedge clk) begin
    if (irq_o) irq_seen = irq_seen + 1;
    if (timer_o != last_timer) tog_seen = tog_seen + 1;
    last_timer = timer_o;
  end

  function automatic int ratio_of(int sel);
    case (sel)
      1: return 4;   2: return 10;  3: return 16;  4: return 50;
      5: return 64;  6: return 100; 7: return 200; default: return 1;
    endcase
  endfunction

  function automatic int period_of(int sel, int d);
    return ratio_of(sel) * ((d == 0) ? 256 : d);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(logic [4:0] v);
    ctrl_wdata_i = v; ctrl_we_i = 1'b1;
    @(negedge clk); ctrl_we_i = 1'b0;
  endtask

  task automatic wr_data(logic [7:0] v);
    data_wdata_i = v; data_we_i = 1'b1;
    @(negedge clk); data_we_i = 1'b0;
  endtask

  task automatic run_delay(int sel, int d);
    int n;
    wr_ctrl(5'h10);
    wr_data(8'(d));
    wr_ctrl(5'(sel));
    n = period_of(sel, d);
    repeat (n - 1) @(negedge clk);
    chk(timer_o == 1'b0, "R3 early", timer_o, 0);
    chk(irq_o == 1'b0, "R4 early irq", irq_o, 0);
    @(negedge clk);
    chk(timer_o == 1'b1, "R3 timeout", timer_o, 1);
    chk(irq_o == 1'b1, "R4 irq", irq_o, 1);
    chk(count_o == 8'(d), "R4 reload", count_o, d);
    @(negedge clk);
    chk(irq_o == 1'b0, "R4 irq single", irq_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int b, t, d0;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(count_o == 0, "R1 count", count_o, 0);
    chk(timer_o == 0, "R1 timer", timer_o, 0);
    chk(irq_o == 0, "R1 irq", irq_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2: stopped holds, data write loads
    wr_data(8'd5);
    chk(count_o == 5, "R2 load", count_o, 5);
    repeat (50) @(negedge clk);
    chk(count_o == 5, "R2 hold", count_o, 5);

    // R3/R4: every ratio, then random
    for (int s = 1; s <= 7; s++) run_delay(s, $urandom_range(1, 6));
    for (int k = 0; k < 6; k++) run_delay($urandom_range(1, 7), $urandom_range(1, 12));
    run_delay(1, 1);

    // R5: zero means 256
    run_delay(1, 0);
    chk(count_o == 0, "R5 wrap reload", count_o, 0);

    // R6: running data write deferred
    wr_ctrl(5'h10); wr_data(8'd5); wr_ctrl(5'd1);
    repeat (2) @(negedge clk);
    wr_data(8'd9);
    chk(count_o == 5, "R6 no direct load", count_o, 5);
    repeat (16) @(negedge clk);
    @(negedge clk);
    chk(timer_o == 1, "R6 timeout", timer_o, 1);
    chk(count_o == 9, "R6 new reload", count_o, 9);

    // R7: output clear bit
    wr_ctrl(5'h11);
    chk(timer_o == 0, "R7 clear", timer_o, 0);

    // R10: ratio change restarts prescaler
    wr_ctrl(5'h10); wr_data(8'd50); wr_ctrl(5'd7);
    repeat (150) @(negedge clk);
    chk(count_o == 50, "R10 slow no tick", count_o, 50);
    wr_ctrl(5'd1);
    repeat (3) @(negedge clk);
    chk(count_o == 50, "R10 before full", count_o, 50);
    @(negedge clk);
    chk(count_o == 49, "R10 full period", count_o, 49);

    // R8: event count
    wr_ctrl(5'h10); wr_data(8'd3); wr_ctrl(5'd8);
    repeat (300) @(negedge clk);
    chk(count_o == 3, "R8 idle", count_o, 3);
    b = irq_seen;
    for (int p = 0; p < 2; p++) begin
      event_i = 1'b1; repeat (2) @(negedge clk);
      event_i = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(count_o == 1, "R8 two edges", count_o, 1);
    event_i = 1'b1; repeat (2) @(negedge clk);
    event_i = 1'b0; repeat (5) @(negedge clk);
    chk(count_o == 3, "R8 reload", count_o, 3);
    chk(timer_o == 1, "R8 toggle", timer_o, 1);
    chk(irq_seen - b == 1, "R8 irq", irq_seen - b, 1);

    // R9: gated counting, irq on gate fall
    wr_ctrl(5'h10); wr_data(8'd0); wr_ctrl(5'd9);
    repeat (100) @(negedge clk);
    chk(count_o == 0, "R9 gate low hold", count_o, 0);
    b = irq_seen;
    gate_i = 1'b1; repeat (400) @(negedge clk);
    d0 = 256 - int'(count_o);
    chk(d0 >= 98 && d0 <= 100, "R9 gated ticks", d0, 100);
    gate_i = 1'b0; repeat (5) @(negedge clk);
    chk(irq_seen - b == 1, "R9 fall irq", irq_seen - b, 1);
    t = int'(count_o);
    repeat (50) @(negedge clk);
    chk(int'(count_o) == t, "R9 hold after fall", count_o, t);

    wr_ctrl(5'h10); wr_data(8'd1); wr_ctrl(5'd9);
    b = irq_seen; t = tog_seen;
    gate_i = 1'b1; repeat (40) @(negedge clk);
    chk(irq_seen == b, "R9 no timeout irq", irq_seen - b, 0);
    chk(tog_seen - t >= 8, "R9 timeouts toggle", tog_seen - t, 9);
    gate_i = 1'b0; repeat (5) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule